// File: doc/BRIEF.md
# Register Frame Save/Restore Sequencer

This block moves a whole frame of eight 32-bit general registers between the register file and stack memory in response to one command. A save command pushes the eight registers below the current stack pointer. A restore command pulls them back from the pointer upwards. Each case is a fixed sequence of eight dword accesses over a simple request/ready memory port. The stack pointer is adjusted by one frame (32 bytes) in a single update at the end. A restore writes the register file in the same cycle as that pointer update. A stack-width input selects full 32-bit pointer arithmetic or narrow 16-bit arithmetic. In narrow mode only the low half of the pointer takes part, and it wraps modulo 2^16.

The controller is a five-state machine:
- **IDLE**: waits for `start`. It latches the command, the width mode and the pointer, and snapshots the registers into a holding bank.
- **XFER**: issues one access per slot. It advances on `mem_ready` and leaves for COMMIT after slot 7 is accepted, or for FAULT on `mem_fault`.
- **COMMIT**: drives the single atomic pointer write. On a restore it also drives the register-file write.
- **DONE**: pulses `done`.
- **FAULT**: pulses `fault`.

Both DONE and FAULT return to IDLE. On a fault nothing is committed.

Top module: `regstack_seq`

## Requirements
- R1: A save issues eight writes in slot order k = 0..7. Slot k goes to address SP-4(k+1) and carries register k. Slot 4 (address SP-20) carries the stack pointer value latched at start, not any partly adjusted value.
- R2: When a save completes, `sp_we` pulses once with SP-32 and `gpr_we` stays 0.
- R3: A restore issues eight reads (`mem_we`=0) at SP+4k for k = 0..7, ascending. The dword at SP+4k is returned to register 7-k.
- R4: During a restore, the dword read at SP+12 is discarded. `gpr_wmask` bit 4 is 0, and bit i is 1 for every other register i. `sp_wdata` is SP+32.
- R5: The register-file write and the pointer write happen together in one cycle, exactly once, and only after the eighth access has been accepted.
- R6: With `stack16`=1, each address is {16'h0, (SP[15:0] ± offset) mod 2^16}. The committed pointer keeps SP[31:16] and updates only the low half. Slot 4 of a save still stores the full 32-bit SP.
- R7: An access is held with a stable address, write enable and data until `mem_ready` or `mem_fault`. Exactly one access completes per `mem_ready`, and wait cycles are tolerated.
- R8: If `mem_fault` is seen on an access, the sequencer issues no further access and commits neither the pointer nor the registers. `fault` is high for exactly one cycle, and `done` is not pulsed.
- R9: `done` is high for exactly one cycle, the cycle after the commit. After reset, `done`, `fault`, `mem_req`, `sp_we` and `gpr_we` are 0.
- R10: `start` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled in IDLE) |
| op_restore | input | 1 | 0 = save frame, 1 = restore frame |
| stack16 | input | 1 | 1 = 16-bit pointer arithmetic |
| gpr_in | input | 256 | Register file contents, register i at bits [32i+31:32i] |
| sp_in | input | 32 | Current stack pointer |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the dword |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted/completed this cycle |
| mem_fault | input | 1 | Access faulted this cycle (wins over ready) |
| gpr_we | output | 1 | Register-file write strobe |
| gpr_wmask | output | 8 | Registers written by gpr_we |
| gpr_wdata | output | 256 | Register values, same packing as gpr_in |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | New stack pointer |
| done | output | 1 | Operation completed |
| fault | output | 1 | Operation aborted by a memory fault |

## Verification
The assertions assume that the memory port never raises `mem_ready` or `mem_fault` while `mem_req` is low. They also assume that `gpr_in` and `sp_in` only matter on the cycle `start` is taken. The bench memory responder answers only requests that are present, and it raises at most one of ready and fault per cycle. The bench changes the register and pointer inputs only between operations. The one deliberate `start` pulse during a busy operation is aimed at R10.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_COMMIT,
        ST_DONE,
        ST_FAULT
    } seq_state_e;
endpackage

// File: rtl/regstack_addr.sv
// Address and final-pointer generation for one frame slot.
module regstack_addr #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int LOW_W    = 16,
    parameter int SLOT_W   = 3
) (
    input  logic [DATA_W-1:0] base,
    input  logic              narrow,
    input  logic              restore,
    input  logic [SLOT_W-1:0] slot,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] final_sp
);
    localparam int BYTES = DATA_W / 8;
    localparam int FRAME = NUM_REGS * BYTES;

    logic [DATA_W-1:0] step_off;
    logic [DATA_W-1:0] full_addr;
    logic [DATA_W-1:0] full_end;

    always_comb begin
        step_off = DATA_W'(slot) * DATA_W'(BYTES);
        if (restore) begin
            full_addr = base + step_off;
            full_end  = base + DATA_W'(FRAME);
        end else begin
            full_addr = base - step_off - DATA_W'(BYTES);
            full_end  = base - DATA_W'(FRAME);
        end
        // modular arithmetic: the low half depends only on low-half operands
        if (narrow) begin
            addr     = {{(DATA_W-LOW_W){1'b0}}, full_addr[LOW_W-1:0]};
            final_sp = {base[DATA_W-1:LOW_W], full_end[LOW_W-1:0]};
        end else begin
            addr     = full_addr;
            final_sp = full_end;
        end
    end
endmodule

// File: rtl/regstack_order.sv
// Slot-to-register mapping for both directions.
module regstack_order #(
    parameter int NUM_REGS = 8,
    parameter int SP_SLOT  = 4,
    parameter int SLOT_W   = 3
) (
    input  logic              restore,
    input  logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] reg_idx,
    output logic              discard
);
    always_comb begin
        reg_idx = restore ? (SLOT_W'(NUM_REGS - 1) - slot) : slot;
        discard = restore && (reg_idx == SLOT_W'(SP_SLOT));
    end
endmodule

// File: rtl/regstack_hold.sv
// Holding bank: snapshot source for saves, staging area for restores.
module regstack_hold #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SLOT_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       snap_en,
    input  logic [NUM_REGS*DATA_W-1:0] snap_data,
    input  logic                       cap_en,
    input  logic [SLOT_W-1:0]          cap_idx,
    input  logic [DATA_W-1:0]          cap_data,
    output logic [NUM_REGS*DATA_W-1:0] bank
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_lane
        logic [DATA_W-1:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (snap_en) begin
                lane_q <= snap_data[g*DATA_W +: DATA_W];
            end else if (cap_en && (cap_idx == SLOT_W'(g))) begin
                lane_q <= cap_data;
            end
        end
        assign bank[g*DATA_W +: DATA_W] = lane_q;
    end
endmodule

// File: rtl/regstack_seq.sv
module regstack_seq #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SP_SLOT  = 4,
    parameter int LOW_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       op_restore,
    input  logic                       stack16,
    input  logic [NUM_REGS*DATA_W-1:0] gpr_in,
    input  logic [DATA_W-1:0]          sp_in,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [DATA_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_ready,
    input  logic                       mem_fault,
    output logic                       gpr_we,
    output logic [NUM_REGS-1:0]        gpr_wmask,
    output logic [NUM_REGS*DATA_W-1:0] gpr_wdata,
    output logic                       sp_we,
    output logic [DATA_W-1:0]          sp_wdata,
    output logic                       done,
    output logic                       fault
);
    import regstack_pkg::*;

    localparam int SLOT_W = $clog2(NUM_REGS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_REGS - 1);
    localparam logic [NUM_REGS-1:0] RESTORE_MASK = ~(NUM_REGS'(1) << SP_SLOT);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] base_q;
    logic              restore_q;
    logic              narrow_q;

    logic                       take_start;
    logic [NUM_REGS*DATA_W-1:0] snap_vec;
    logic [NUM_REGS*DATA_W-1:0] bank;
    logic [SLOT_W-1:0]          reg_idx;
    logic                       discard;
    logic [DATA_W-1:0]          slot_addr;
    logic [DATA_W-1:0]          end_sp;
    logic                       accepted;

    assign take_start = (state_q == ST_IDLE) && start;
    assign accepted   = (state_q == ST_XFER) && mem_ready && !mem_fault;

    always_comb begin
        snap_vec = gpr_in;
        snap_vec[SP_SLOT*DATA_W +: DATA_W] = sp_in;
    end

    regstack_order #(.NUM_REGS(NUM_REGS), .SP_SLOT(SP_SLOT), .SLOT_W(SLOT_W)) u_order (
        .restore (restore_q),
        .slot    (slot_q),
        .reg_idx (reg_idx),
        .discard (discard)
    );

    regstack_addr #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .LOW_W(LOW_W), .SLOT_W(SLOT_W)) u_addr (
        .base     (base_q),
        .narrow   (narrow_q),
        .restore  (restore_q),
        .slot     (slot_q),
        .addr     (slot_addr),
        .final_sp (end_sp)
    );

    regstack_hold #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SLOT_W(SLOT_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .snap_en   (take_start),
        .snap_data (snap_vec),
        .cap_en    (accepted && restore_q && !discard),
        .cap_idx   (reg_idx),
        .cap_data  (mem_rdata),
        .bank      (bank)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_XFER;
            ST_XFER: begin
                if (mem_fault) state_d = ST_FAULT;
                else if (mem_ready && slot_q == LAST_SLOT) state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            slot_q    <= '0;
            base_q    <= '0;
            restore_q <= 1'b0;
            narrow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                slot_q    <= '0;
                base_q    <= sp_in;
                restore_q <= op_restore;
                narrow_q  <= stack16;
            end else if (accepted && slot_q != LAST_SLOT) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_we    = mem_req && !restore_q;
        mem_addr  = slot_addr;
        mem_wdata = bank[reg_idx*DATA_W +: DATA_W];
        sp_we     = (state_q == ST_COMMIT);
        sp_wdata  = end_sp;
        gpr_we    = sp_we && restore_q;
        gpr_wmask = gpr_we ? RESTORE_MASK : '0;
        gpr_wdata = bank;
        done      = (state_q == ST_DONE);
        fault     = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/regstack_seq_chk.sv
module regstack_seq_chk #(
    parameter int DATA_W = 32,
    parameter int LOW_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              mem_fault,
    input logic              gpr_we,
    input logic              sp_we,
    input logic              done,
    input logic              fault,
    input logic              restore_q,
    input logic              narrow_q
);
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready && !mem_fault |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_restore_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && restore_q |-> !mem_we);

    assert_atomic_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> sp_we && !mem_req);

    assert_done_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |=> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_no_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_fault |=> fault && !sp_we && !gpr_we && !mem_req);

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault && !done);

    assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && narrow_q |-> mem_addr[DATA_W-1:LOW_W] == '0);
endmodule

bind regstack_seq regstack_seq_chk #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .mem_fault (mem_fault),
    .gpr_we    (gpr_we),
    .sp_we     (sp_we),
    .done      (done),
    .fault     (fault),
    .restore_q (restore_q),
    .narrow_q  (narrow_q)
);

// File: tb/regstack_seq_test.sv
`timescale 1ns/1ps
module regstack_seq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_restore = 1'b0;
    logic         stack16 = 1'b0;
    logic [255:0] gpr_in = '0;
    logic [31:0]  sp_in = '0;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic         mem_ready = 1'b0;
    logic         mem_fault = 1'b0;
    logic         gpr_we, sp_we, done, fault;
    logic [7:0]   gpr_wmask;
    logic [255:0] gpr_wdata;
    logic [31:0]  sp_wdata;

    regstack_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_restore(op_restore), .stack16(stack16),
        .gpr_in(gpr_in), .sp_in(sp_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .mem_fault(mem_fault), .gpr_we(gpr_we),
        .gpr_wmask(gpr_wmask), .gpr_wdata(gpr_wdata), .sp_we(sp_we),
        .sp_wdata(sp_wdata), .done(done), .fault(fault)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [31:0] mem_model [logic [31:0]];
    logic [31:0] regs [8];

    // responder and monitor state
    int          wait_cfg = 0;
    int          fault_at = -1;
    int          wait_cnt = 0;
    int          acc_n = 0;
    logic [31:0] acc_addr [16];
    logic        acc_we [16];
    logic [31:0] acc_wdata [16];
    int          cyc = 0;
    int          commit_n = 0, gwe_n = 0, done_n = 0, fault_n = 0;
    int          commit_cyc = 0, done_cyc = 0, acc_at_commit = 0;
    logic [7:0]  cap_mask;
    logic [255:0] cap_gdata;
    logic [31:0] cap_sp;

    always @(negedge clk) begin
        mem_ready = 1'b0;
        mem_fault = 1'b0;
        if (mem_req) begin
            if (wait_cnt < wait_cfg) begin
                wait_cnt++;
            end else if (acc_n == fault_at) begin
                mem_fault = 1'b1;
                wait_cnt = 0;
            end else begin
                mem_ready = 1'b1;
                wait_cnt = 0;
                if (acc_n < 16) begin
                    acc_addr[acc_n] = mem_addr;
                    acc_we[acc_n] = mem_we;
                    acc_wdata[acc_n] = mem_wdata;
                end
                acc_n++;
                if (mem_we) mem_model[mem_addr] = mem_wdata;
                else mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sp_we) begin
                commit_n++;
                commit_cyc = cyc;
                acc_at_commit = acc_n;
                cap_sp = sp_wdata;
            end
            if (gpr_we) begin
                gwe_n++;
                cap_mask = gpr_wmask;
                cap_gdata = gpr_wdata;
            end
            if (done) begin done_n++; done_cyc = cyc; end
            if (fault) fault_n++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_addr(input logic [31:0] sp, input bit n16, input bit rs, input int k);
        logic [31:0] a;
        a = rs ? sp + 32'(4 * k) : sp - 32'(4 * (k + 1));
        if (n16) a = {16'h0, a[15:0]};
        return a;
    endfunction

    function automatic logic [31:0] e_end(input logic [31:0] sp, input bit n16, input bit rs);
        logic [31:0] a;
        a = rs ? sp + 32'd32 : sp - 32'd32;
        if (n16) a = {sp[31:16], a[15:0]};
        return a;
    endfunction

    task automatic load_regs(input logic [31:0] seed);
        for (int i = 0; i < 8; i++) begin
            regs[i] = seed ^ (32'h0101_0101 * 32'(i + 1));
            gpr_in[i*32 +: 32] = regs[i];
        end
    endtask

    task automatic run_op(input bit rs, input bit n16, input logic [31:0] sp,
                          input int waits, input int fat, input bit poke);
        acc_n = 0; commit_n = 0; gwe_n = 0; done_n = 0; fault_n = 0;
        wait_cfg = waits; fault_at = fat;
        @(negedge clk);
        op_restore = rs; stack16 = n16; sp_in = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            op_restore = ~rs; sp_in = sp ^ 32'h00F0_0000; start = 1'b1;
            @(negedge clk);
            start = 1'b0; op_restore = rs; sp_in = sp;
        end
        for (int n = 0; n < 500; n++) begin
            @(posedge clk);
            if (done_n != 0 || fault_n != 0) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic check_save(input logic [31:0] sp, input bit n16, input string tag);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] ev;
            ev = (k == 4) ? sp : regs[k];
            chk(acc_addr[k] == e_addr(sp, n16, 0, k), {tag, " R1 save address"}, acc_addr[k], e_addr(sp, n16, 0, k));
            chk(acc_we[k] && acc_wdata[k] == ev, {tag, " R1 save data"}, acc_wdata[k], ev);
        end
        chk(acc_n == 8, {tag, " R7 access count"}, 32'(acc_n), 32'd8);
        chk(commit_n == 1 && gwe_n == 0, {tag, " R2 single sp commit, no gpr write"}, 32'(commit_n * 16 + gwe_n), 32'd16);
        chk(cap_sp == e_end(sp, n16, 0), {tag, " R2 new sp"}, cap_sp, e_end(sp, n16, 0));
        chk(done_n == 1 && done_cyc == commit_cyc + 1, {tag, " R9 done one cycle after commit"}, 32'(done_cyc), 32'(commit_cyc + 1));
    endtask

    task automatic fill_frame(input logic [31:0] sp, input bit n16, input logic [31:0] seed);
        for (int k = 0; k < 8; k++) mem_model[e_addr(sp, n16, 1, k)] = seed + 32'(k * 32'h1111);
    endtask

    task automatic check_restore(input logic [31:0] sp, input bit n16, input logic [31:0] seed, input string tag);
        for (int k = 0; k < 8; k++) begin
            chk(acc_addr[k] == e_addr(sp, n16, 1, k) && !acc_we[k], {tag, " R3 restore read address"}, acc_addr[k], e_addr(sp, n16, 1, k));
            if (k != 3)
                chk(cap_gdata[(7-k)*32 +: 32] == seed + 32'(k * 32'h1111), {tag, " R3 register value"},
                    cap_gdata[(7-k)*32 +: 32], seed + 32'(k * 32'h1111));
        end
        chk(cap_mask == 8'hEF, {tag, " R4 slot +12 discarded, mask"}, {24'h0, cap_mask}, 32'hEF);
        chk(cap_sp == e_end(sp, n16, 1), {tag, " R4 new sp"}, cap_sp, e_end(sp, n16, 1));
        chk(commit_n == 1 && gwe_n == 1 && acc_at_commit == 8, {tag, " R5 atomic commit after 8th read"},
            32'(acc_at_commit), 32'd8);
        chk(done_n == 1 && done_cyc == commit_cyc + 1, {tag, " R9 done timing"}, 32'(done_cyc), 32'(commit_cyc + 1));
    endtask

    task automatic t_reset;
        chk(!mem_req && !done && !fault && !sp_we && !gpr_we, "R9 reset state",
            {27'h0, mem_req, done, fault, sp_we, gpr_we}, 32'h0);
    endtask

    task automatic t_save32;
        load_regs(32'hA5A5_0000);
        run_op(0, 0, 32'h0001_0100, 0, -1, 0);
        check_save(32'h0001_0100, 0, "save32");
        for (int k = 0; k < 8; k++)
            chk(mem_model[32'h0001_0100 - 32'(4*(k+1))] == ((k == 4) ? 32'h0001_0100 : regs[k]),
                "R1 memory image", mem_model[32'h0001_0100 - 32'(4*(k+1))], (k == 4) ? 32'h0001_0100 : regs[k]);
    endtask

    task automatic t_save32_wrap;
        load_regs(32'h1234_5678);
        run_op(0, 0, 32'h0000_0010, 0, -1, 0);
        check_save(32'h0000_0010, 0, "save32 wrap");
    endtask

    task automatic t_restore32;
        fill_frame(32'h0002_0040, 0, 32'hC000_0001);
        run_op(1, 0, 32'h0002_0040, 0, -1, 0);
        check_restore(32'h0002_0040, 0, 32'hC000_0001, "restore32");
    endtask

    task automatic t_save16_wrap;
        load_regs(32'h0BAD_F00D);
        run_op(0, 1, 32'hABCD_0010, 0, -1, 0);
        check_save(32'hABCD_0010, 1, "save16 R6");
        chk(acc_addr[4] == 32'h0000_FFFC, "R6 narrow wrap slot 4", acc_addr[4], 32'h0000_FFFC);
        chk(cap_sp == 32'hABCD_FFF0, "R6 narrow pointer keeps upper half", cap_sp, 32'hABCD_FFF0);
    endtask

    task automatic t_restore16_wrap;
        fill_frame(32'h1234_FFF0, 1, 32'h7700_0000);
        run_op(1, 1, 32'h1234_FFF0, 0, -1, 0);
        check_restore(32'h1234_FFF0, 1, 32'h7700_0000, "restore16 R6");
        chk(cap_sp == 32'h1234_0010, "R6 narrow restore pointer", cap_sp, 32'h1234_0010);
    endtask

    task automatic t_waits;
        load_regs(32'h3C3C_0000);
        run_op(0, 0, 32'h0003_0000, 2, -1, 0);
        check_save(32'h0003_0000, 0, "save wait R7");
        fill_frame(32'h0004_0000, 0, 32'h5500_0000);
        run_op(1, 0, 32'h0004_0000, 3, -1, 0);
        check_restore(32'h0004_0000, 0, 32'h5500_0000, "restore wait R7");
    endtask

    task automatic t_fault;
        fill_frame(32'h0005_0000, 0, 32'h9900_0000);
        run_op(1, 0, 32'h0005_0000, 1, 4, 0);
        chk(fault_n == 1, "R8 fault pulse", 32'(fault_n), 32'd1);
        chk(commit_n == 0 && gwe_n == 0 && done_n == 0, "R8 no commit on fault",
            32'(commit_n + gwe_n + done_n), 32'd0);
        chk(acc_n == 4, "R8 accesses stop at fault", 32'(acc_n), 32'd4);
        load_regs(32'h6600_0000);
        run_op(0, 0, 32'h0006_0000, 0, 2, 0);
        chk(fault_n == 1 && commit_n == 0 && done_n == 0, "R8 save fault no pointer update",
            32'(commit_n), 32'd0);
        chk(acc_n == 2, "R8 save stops", 32'(acc_n), 32'd2);
    endtask

    task automatic t_busy;
        load_regs(32'h2222_0000);
        run_op(0, 0, 32'h0007_0080, 1, -1, 1);
        check_save(32'h0007_0080, 0, "busy R10");
        chk(acc_n == 8 && commit_n == 1, "R10 start ignored while busy", 32'(acc_n), 32'd8);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_save32();
        t_save32_wrap();
        t_restore32();
        t_save16_wrap();
        t_restore16_wrap();
        t_waits();
        t_fault();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule